// File: doc/BRIEF.md
# Triggered Voice Message Playback Sequencer

This block runs the playback of a voice chip that stores several messages. Ten active-low trigger pads wait for a press. A falling edge on pad n while the block is idle starts message n. The block first reads that message's start address from a table of three-byte pointers at the bottom of the message memory. It then fetches one data byte every eight sample periods and presents the byte one bit per sample period, most significant bit first, to a one-bit delta-modulation decoder that lies outside this block.

While a message plays, the block holds the memory read-enable low. It also drives the active message's trigger pad low, so the pad reports that the block is busy. The message ends when the reserved marker byte 0xAA is fetched. The block then releases the pad and the read-enable and returns to idle. The core clock runs at SMP_DIV (default 64) times the sample rate. A sample clock output gives a square wave at the sample rate.

Each pad is split into its input level and a drive-low enable. Outside the block the pad is pulled up, so its level is the external level ANDed with the inverse of the drive.

Top module: `msg_play_seq`

## Requirements
- R1: While `rst` is high the block is idle: `rd_n` is 1, `trig_drv` is 0 and `bit_stb` is 0. This holds even if `rst` rises during playback. After `rst` falls the block stays idle until a new trigger arrives.
- R2: A falling edge on `trig_n_i[n]` while idle reads the bytes at addresses 3n, 3n+1 and 3n+2, taken as the high, middle and low byte of a 24-bit value. The low 17 bits of that value are the message start address. After the first data byte is taken, `mem_addr` holds the start address plus one.
- R3: From the start of a message until its end, `rd_n` is 0. For message n, `trig_drv` has exactly bit n set. Both are released together when the message ends.
- R4: Data bits leave on `bit_out`, most significant bit first. Each bit lasts SMP_DIV cycles, and `bit_stb` is 1 only on the first cycle of each bit.
- R5: A fetched byte equal to 0xAA ends the message without being played. A message whose first byte is 0xAA plays no bits and returns to idle.
- R6: If several pads fall in the same cycle, the lowest-numbered one starts.
- R7: Triggers that arrive during playback are ignored. They do not change `trig_drv` and do not start a message afterwards.
- R8: `smp_clk` has a period of SMP_DIV cycles and is high for the first SMP_DIV/2 cycles. Every `bit_stb` falls in a cycle where `smp_clk` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, SMP_DIV times the sample rate |
| rst | input | 1 | Active-high, level-sensitive reset to idle |
| trig_n_i | input | 10 | Level seen on each trigger pad (active low) |
| trig_drv | output | 10 | Pad drive-low enable, bit n set while message n plays |
| mem_addr | output | 17 | Message memory address |
| mem_data | input | 8 | Byte returned by the memory one cycle after the address |
| rd_n | output | 1 | Active-low memory read-enable, low during playback |
| smp_clk | output | 1 | Square wave at the sample rate |
| bit_out | output | 1 | Current data bit for the decoder |
| bit_stb | output | 1 | One-cycle mark at the start of each data bit |

## Verification
Several rules are checked by assertions on every cycle: the read-enable and the pad drive agree with each other, at most one pad is driven, the driven pad does not change during a message, strobes occur only during playback and only while the sample clock is high, and reset forces idle on the next cycle. The bench's scenarios are needed to show the rest: the pointer decode and its 17-bit truncation, the exact bit order of each message, the end marker, lowest-pad priority, and that triggers arriving during playback are dropped. To do this, the bench computes each message's bit stream from its own memory image and compares it bit by bit with the strobed output.

// File: rtl/msp_pkg.sv
package msp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PTR_WAIT = 3'd1,
        ST_PTR_TAKE = 3'd2,
        ST_DAT_WAIT = 3'd3,
        ST_DAT_TAKE = 3'd4,
        ST_PLAY     = 3'd5
    } msp_state_e;

endpackage

// File: rtl/msp_trig_front.sv
// Synchronises the trigger pads, finds falling edges and picks the lowest one.
module msp_trig_front #(
    parameter int N      = 10,
    parameter int STAGES = 2,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     pin_n,
    output logic             fire,
    output logic [IDX_W-1:0] idx
);

    logic [N-1:0] sync_d [STAGES];
    logic [N-1:0] sync_q [STAGES];
    logic [N-1:0] prev_d, prev_q;
    logic [N-1:0] fall;

    always_comb begin
        sync_d[0] = pin_n;
        for (int s = 1; s < STAGES; s++) begin
            sync_d[s] = sync_q[s-1];
        end
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                sync_q[s] <= '1;
            end
            prev_q <= '1;
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                sync_q[s] <= sync_d[s];
            end
            prev_q <= prev_d;
        end
    end

    assign fall = prev_q & ~sync_q[STAGES-1];

    // Scan from the top down so that the lowest set bit is the last write.
    always_comb begin
        fire = |fall;
        idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (fall[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/msp_rate_div.sv
// Sample-rate divider; restarting it lines bit periods up with the counter.
module msp_rate_div #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic first,
    output logic last,
    output logic sq
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HALF  = DIV / 2;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || last) cnt_d = '0;
        else                 cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign first = (cnt_q == '0);
    assign last  = (cnt_q == CNT_W'(DIV - 1));
    assign sq    = (cnt_q < CNT_W'(HALF));

endmodule

// File: rtl/msg_play_seq.sv
module msg_play_seq #(
    parameter int                NUM_MSG     = 10,
    parameter int                ADDR_W      = 17,
    parameter int                DATA_W      = 8,
    parameter int                SMP_DIV     = 64,
    parameter int                ENTRY_BYTES = 3,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] END_MARK    = DATA_W'(8'hAA)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_MSG-1:0] trig_n_i,
    output logic [NUM_MSG-1:0] trig_drv,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_data,
    output logic               rd_n,
    output logic               smp_clk,
    output logic               bit_out,
    output logic               bit_stb
);
    import msp_pkg::*;

    localparam int IDX_W  = (NUM_MSG > 1) ? $clog2(NUM_MSG) : 1;
    localparam int BCNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int PCNT_W = (ENTRY_BYTES > 1) ? $clog2(ENTRY_BYTES) : 1;
    localparam int PTR_W  = (ENTRY_BYTES - 1) * DATA_W;
    localparam int FULL_W = ENTRY_BYTES * DATA_W;

    typedef struct packed {
        msp_state_e         st;
        logic [IDX_W-1:0]   msg;
        logic [ADDR_W-1:0]  addr;
        logic [PTR_W-1:0]   ptr;
        logic [PCNT_W-1:0]  pcnt;
        logic [DATA_W-1:0]  sh;
        logic [BCNT_W-1:0]  bcnt;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              trig_fire;
    logic [IDX_W-1:0]  trig_idx;
    logic              div_first, div_last, div_restart;
    logic [FULL_W-1:0] ptr_full;
    logic              is_mark;

    msp_trig_front #(
        .N      (NUM_MSG),
        .STAGES (SYNC_STAGES),
        .IDX_W  (IDX_W)
    ) u_trig (
        .clk   (clk),
        .rst   (rst),
        .pin_n (trig_n_i),
        .fire  (trig_fire),
        .idx   (trig_idx)
    );

    assign is_mark     = (mem_data == END_MARK);
    assign div_restart = (ctl_q.st == ST_DAT_TAKE) && !is_mark;

    msp_rate_div #(
        .DIV (SMP_DIV)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (div_restart),
        .first   (div_first),
        .last    (div_last),
        .sq      (smp_clk)
    );

    assign ptr_full = {ctl_q.ptr, mem_data};

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (trig_fire) begin
                    ctl_d.st   = ST_PTR_WAIT;
                    ctl_d.msg  = trig_idx;
                    ctl_d.addr = ADDR_W'(trig_idx) * ADDR_W'(ENTRY_BYTES);
                    ctl_d.pcnt = '0;
                end
            end
            ST_PTR_WAIT: ctl_d.st = ST_PTR_TAKE;
            ST_PTR_TAKE: begin
                if (ctl_q.pcnt == PCNT_W'(ENTRY_BYTES - 1)) begin
                    ctl_d.addr = ptr_full[ADDR_W-1:0];
                    ctl_d.st   = ST_DAT_WAIT;
                end else begin
                    ctl_d.ptr  = PTR_W'(ptr_full);
                    ctl_d.pcnt = ctl_q.pcnt + PCNT_W'(1);
                    ctl_d.addr = ctl_q.addr + ADDR_W'(1);
                    ctl_d.st   = ST_PTR_WAIT;
                end
            end
            ST_DAT_WAIT: ctl_d.st = ST_DAT_TAKE;
            ST_DAT_TAKE: begin
                if (is_mark) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.sh   = mem_data;
                    ctl_d.bcnt = '0;
                    ctl_d.addr = ctl_q.addr + ADDR_W'(1);
                    ctl_d.st   = ST_PLAY;
                end
            end
            ST_PLAY: begin
                if (div_last) begin
                    if (ctl_q.bcnt == BCNT_W'(DATA_W - 1)) begin
                        // Address has sat on the next byte for a whole byte time.
                        if (is_mark) begin
                            ctl_d.st = ST_IDLE;
                        end else begin
                            ctl_d.sh   = mem_data;
                            ctl_d.bcnt = '0;
                            ctl_d.addr = ctl_q.addr + ADDR_W'(1);
                        end
                    end else begin
                        ctl_d.sh   = ctl_q.sh << 1;
                        ctl_d.bcnt = ctl_q.bcnt + BCNT_W'(1);
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    logic busy;
    assign busy = (ctl_q.st != ST_IDLE);

    always_comb begin
        for (int i = 0; i < NUM_MSG; i++) begin
            trig_drv[i] = busy && (ctl_q.msg == IDX_W'(i));
        end
    end

    assign mem_addr = ctl_q.addr;
    assign rd_n     = !busy;
    assign bit_out  = (ctl_q.st == ST_PLAY) && ctl_q.sh[DATA_W-1];
    assign bit_stb  = (ctl_q.st == ST_PLAY) && div_first;

endmodule

// File: rtl/msp_checker.sv
module msp_checker #(
    parameter int NUM_MSG = 10
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_MSG-1:0] trig_drv,
    input logic               rd_n,
    input logic               smp_clk,
    input logic               bit_stb
);

    assert_rst_idle_R1: assert property (@(posedge clk)
        rst |=> (rd_n && (trig_drv == '0) && !bit_stb));

    assert_busy_pad_R3: assert property (@(posedge clk) disable iff (rst)
        rd_n == (trig_drv == '0));

    assert_single_pad_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trig_drv));

    assert_pad_held_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_n |=> (rd_n || $stable(trig_drv)));

    assert_stb_busy_R4: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> !rd_n);

    assert_stb_high_R8: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> smp_clk);

endmodule

bind msg_play_seq msp_checker #(.NUM_MSG(NUM_MSG)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trig_drv (trig_drv),
    .rd_n     (rd_n),
    .smp_clk  (smp_clk),
    .bit_stb  (bit_stb)
);

// File: tb/msg_play_seq_tb.sv
module msg_play_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 64;
    localparam logic [7:0] MARK = 8'hAA;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  ext_n = '1;
    logic [9:0]  pin_n;
    logic [9:0]  trig_drv;
    logic [16:0] mem_addr;
    logic [7:0]  mem_data = '0;
    logic        rd_n, smp_clk, bit_out, bit_stb;
    logic [7:0]  rom [256];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pin_n = ext_n & ~trig_drv;

    always_ff @(posedge clk) mem_data <= rom[mem_addr[7:0]];

    msg_play_seq u_dut (
        .clk      (clk),
        .rst      (rst),
        .trig_n_i (pin_n),
        .trig_drv (trig_drv),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .rd_n     (rd_n),
        .smp_clk  (smp_clk),
        .bit_out  (bit_out),
        .bit_stb  (bit_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_entry(input int k, input int start);
        rom[3*k]   = 8'((start >> 16) & 'hFF);
        rom[3*k+1] = 8'((start >> 8) & 'hFF);
        rom[3*k+2] = 8'(start & 'hFF);
    endtask

    // Driver side of the scoreboard: expected bits from the bench's own image.
    task automatic push_msg(input int k);
        int a;
        a = {rom[3*k+1], rom[3*k+2]} & 'hFF;
        while (rom[a] != MARK) begin
            for (int b = 7; b >= 0; b--) exp_q.push_back(rom[a][b]);
            a = (a + 1) & 'hFF;
        end
    endtask

    task automatic pulse(input logic [9:0] mask);
        @(posedge clk); #1 ext_n = ~mask;
        repeat (4) @(posedge clk);
        #1 ext_n = '1;
    endtask

    task automatic wait_busy(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 50 && !seen; i++) begin
            @(negedge clk);
            if (!rd_n) seen = 1'b1;
        end
    endtask

    task automatic wait_idle(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge clk);
            if (rd_n) seen = 1'b1;
        end
    endtask

    task automatic wait_stb(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (bit_stb) seen = 1'b1;
        end
    endtask

    // Monitor side of the scoreboard.
    always @(negedge clk) begin
        if (!rst && bit_stb) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected bit", int'(bit_out), 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                chk(bit_out == e, "R4 bit order", int'(bit_out), int'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ok;
        int cnt;
        for (int i = 0; i < 256; i++) rom[i] = MARK;
        put_entry(0, 'h000020);
        put_entry(1, 'h000050);
        put_entry(2, 'h000070);
        put_entry(3, 'h000030);
        put_entry(4, 'h000060);
        put_entry(5, 'h000078);
        put_entry(6, 'h000060);
        put_entry(7, 'h000060);
        put_entry(8, 'h000060);
        put_entry(9, 'h030040);   // low 17 bits give 0x10040
        rom['h20] = 8'h5A; rom['h21] = 8'hC3;
        rom['h50] = 8'hF0; rom['h51] = 8'h0F; rom['h52] = 8'h33;
        rom['h70] = 8'h3C;
        rom['h78] = 8'hE7;
        rom['h40] = 8'h81;

        // R1: held in reset
        repeat (5) @(negedge clk);
        chk(rd_n == 1'b1, "R1 rd_n in reset", int'(rd_n), 1);
        chk(trig_drv == '0, "R1 pads in reset", int'(trig_drv), 0);
        chk(bit_stb == 1'b0, "R1 strobe in reset", int'(bit_stb), 0);
        @(posedge clk); #1 rst = 1'b0;
        repeat (10) @(negedge clk);

        // R3, R4, R8: message 0
        push_msg(0);
        pulse(10'b1);
        wait_busy(ok);
        chk(ok, "R3 rd_n low on start", int'(rd_n), 0);
        chk(trig_drv == 10'h001, "R3 pad 0 driven", int'(trig_drv), 'h001);
        wait_stb(ok);
        chk(ok && smp_clk, "R8 strobe with clock high", int'(smp_clk), 1);
        cnt = 0;
        while (smp_clk && cnt < 200) begin cnt++; @(negedge clk); end
        chk(cnt == DIV/2, "R8 high half", cnt, DIV/2);
        cnt = 0;
        while (!smp_clk && cnt < 200) begin cnt++; @(negedge clk); end
        chk(cnt == DIV/2, "R8 low half", cnt, DIV/2);
        chk(bit_stb == 1'b1, "R4 next bit after DIV cycles", int'(bit_stb), 1);
        wait_idle(ok);
        chk(ok && trig_drv == '0, "R3 release at end", int'(trig_drv), 0);
        chk(exp_q.size() == 0, "R5 all bits before marker", exp_q.size(), 0);

        // R5: empty message
        @(posedge clk); #1 ext_n = ~10'h008;
        ok = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (trig_drv == 10'h008) ok = 1'b1;
        end
        chk(ok, "R5 empty message entered play", 0, 1);
        chk(rd_n == 1'b1, "R5 empty message back to idle", int'(rd_n), 1);
        @(posedge clk); #1 ext_n = '1;
        repeat (10) @(negedge clk);

        // R2: pointer with truncated high bits
        push_msg(9);
        pulse(10'h200);
        wait_stb(ok);
        chk(ok && mem_addr == 17'h10041, "R2 address after first byte", int'(mem_addr), 'h10041);
        chk(trig_drv == 10'h200, "R3 pad 9 driven", int'(trig_drv), 'h200);
        wait_idle(ok);
        chk(exp_q.size() == 0, "R2 message 9 complete", exp_q.size(), 0);
        repeat (10) @(negedge clk);

        // R6: two pads at once
        push_msg(2);
        pulse(10'h024);
        wait_busy(ok);
        chk(trig_drv == 10'h004, "R6 lowest pad wins", int'(trig_drv), 'h004);
        wait_idle(ok);
        chk(exp_q.size() == 0, "R6 message 2 played", exp_q.size(), 0);
        repeat (10) @(negedge clk);

        // R7: trigger during play
        push_msg(1);
        pulse(10'h002);
        wait_busy(ok);
        repeat (100) @(negedge clk);
        pulse(10'h010);
        repeat (5) @(negedge clk);
        chk(trig_drv == 10'h002, "R7 pad unchanged", int'(trig_drv), 'h002);
        wait_idle(ok);
        chk(exp_q.size() == 0, "R7 message 1 intact", exp_q.size(), 0);
        repeat (20) @(negedge clk);
        chk(rd_n == 1'b1 && trig_drv == '0, "R7 no late start", int'(trig_drv), 0);

        // R1: reset during playback
        push_msg(1);
        pulse(10'h002);
        wait_busy(ok);
        repeat (200) @(negedge clk);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(rd_n == 1'b1, "R1 reset ends play", int'(rd_n), 1);
        chk(trig_drv == '0, "R1 reset frees pad", int'(trig_drv), 0);
        exp_q.delete();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(rd_n == 1'b1, "R1 idle after reset", int'(rd_n), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule